// File: doc/BRIEF.md
# Serial EEPROM Word Access Engine

This block moves 16-bit words between a host and a serial EEPROM that speaks the common SPI command set. It drives chip select, clock and data itself, so the host does not have to toggle pins in software. The host places a word offset, a word count and a direction on a request port. Read words come back one at a time with a valid strobe. Write words are pulled from the host with a take strobe. A completion pulse, with an error flag, closes every request.

Before every command the engine reads the part's status byte until the busy bit clears. A write is preceded by a write-enable command. A write is split into bursts that never cross a page of the part. After each burst the engine waits a programmable write-cycle time. For parts with eight address bits, the ninth byte-address bit is carried inside the opcode.

The controller is one state machine with eleven states:
- `ST_IDLE`: accepts a request. It goes to `ST_FINISH` when the request is rejected, otherwise to `ST_POLL_CMD`.
- `ST_POLL_CMD`: sends the status opcode, then goes to `ST_POLL_STAT`.
- `ST_POLL_STAT`: reads the status byte. When the part is ready it goes to `ST_CS_PULSE` with resume target `ST_WREN` for a write or `ST_CMD` for a read. When the part is busy it goes to `ST_CS_PULSE` with resume target `ST_POLL_CMD`. When the retry limit is reached it goes to `ST_FINISH` with an error.
- `ST_WREN`: sends the write-enable opcode, then goes to `ST_CS_PULSE` with resume target `ST_CMD`.
- `ST_CS_PULSE`: holds chip select high for a short gap, then goes to the resume target.
- `ST_CMD`: sends the read or write opcode, then goes to `ST_ADDR`.
- `ST_ADDR`: sends the byte address, then goes to `ST_READ_WORD` or `ST_WRITE_WORD`.
- `ST_READ_WORD`: repeats once per word. After the last word it goes to `ST_FINISH`.
- `ST_WRITE_WORD`: repeats once per word. At the last word or at a page end it goes to `ST_WRITE_WAIT`.
- `ST_WRITE_WAIT`: waits the write-cycle time. It then goes to `ST_POLL_CMD` if words remain, otherwise to `ST_FINISH`.
- `ST_FINISH`: pulses done and returns to `ST_IDLE`.

Top module: `spi_eeprom_word_engine`

## Requirements
- R1: A request with offset >= capacity, a count of zero, or offset + count > capacity finishes with `done` and `err` high together. It makes no chip-select activity.
- R2: Every command is preceded by status polling. Each poll is opcode 0x05 followed by 8 status bits read in. The command starts only after a status byte with bit 0 (busy) equal to 0, with chip select driven high between the poll and the command.
- R3: If POLL_LIMIT status reads in a row show busy, the request ends with `err` set and no read or write command is sent. Chip select goes high between the retries.
- R4: Serial bits leave most significant bit first. `spi_mosi` is set while `spi_sck` is low and holds while it is high. `spi_sck` is high only while chip select is low, and it idles low.
- R5: While read data is shifted in, `spi_mosi` stays low. The part's output is sampled at the end of each clock-high phase.
- R6: The address sent after the opcode is the low ADDR_BITS bits of the byte address, which is twice the word offset.
- R7: When ADDR_BITS is 8, byte-address bit 8 is placed into opcode bit 3 (value 0x08) of both the read and write opcodes.
- R8: Each word travels low byte first on the wire, in both directions. The byte at even byte address 2k is bits [7:0] of word k.
- R9: Every write burst is status poll, chip-select pulse, write-enable opcode 0x06, chip-select pulse, then write opcode 0x02 and the address. One `wr_take` pulse marks each word consumed.
- R10: A write burst closes after the word whose next byte address is a multiple of PAGE_BYTES. The remaining words start a new write-enable/write sequence.
- R11: A read sends one read opcode 0x03 and one address, then streams `count` words. Each word gets one `rd_valid` pulse.
- R12: After each write burst, chip select stays high for at least WR_CYCLES clock cycles before the next command.
- R13: `req_ready` is high only when idle, with chip select high. Each accepted request yields exactly one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted on this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | REQ_W | First word offset |
| req_count | input | REQ_W | Number of words |
| wr_data | input | 16 | Next write word, held until `wr_take` |
| wr_take | output | 1 | Pulse: current write word consumed |
| rd_valid | output | 1 | Pulse: `rd_data` holds a read word |
| rd_data | output | 16 | Read word |
| done | output | 1 | Pulse: request finished |
| err | output | 1 | With `done`: request rejected or status timeout |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Data to the part |
| spi_miso | input | 1 | Data from the part |

## Verification
The bench connects a behavioural EEPROM that decodes opcodes, wraps write addresses inside a page, and stays busy for a time after each write. The first pattern is a whole-array write followed by a whole-array read. This pattern exercises page splitting at every boundary and the ninth-bit opcode on the upper half. A sweep over offsets at, just before and just after page ends, and at the top of the array, uses counts of one, two, three and nine words. It separates correct bursts from bursts that wrap inside a page, since a wrap would overwrite the wrong bytes and change the counted write-enable commands. Rejected ranges, a part that never leaves busy, and a read stream crossing byte address 256 cover the error paths and the address carry.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam logic [7:0] OPC_READ   = 8'h03;
    localparam logic [7:0] OPC_WRITE  = 8'h02;
    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_STATUS = 8'h05;
    localparam logic [7:0] OPC_HI_BIT = 8'h08;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL_CMD,
        ST_POLL_STAT,
        ST_CS_PULSE,
        ST_WREN,
        ST_CMD,
        ST_ADDR,
        ST_READ_WORD,
        ST_WRITE_WORD,
        ST_WRITE_WAIT,
        ST_FINISH
    } ee_state_t;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_LOW,
        BS_HIGH
    } bit_state_t;

endpackage

// File: rtl/ee_range_check.sv
module ee_range_check #(
    parameter int CAP_WORDS = 256,
    parameter int REQ_W     = 16
) (
    input  logic [REQ_W-1:0] offset,
    input  logic [REQ_W-1:0] count,
    output logic             bad
);
    localparam int SW = REQ_W + 1;

    logic [SW-1:0] end_pos;

    always_comb begin
        end_pos = {1'b0, offset} + {1'b0, count};
        bad = ({1'b0, offset} >= SW'(CAP_WORDS)) ||
              (count == '0) ||
              (end_pos > SW'(CAP_WORDS));
    end
endmodule

// File: rtl/ee_cycle_counter.sv
module ee_cycle_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (~&cnt)   cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/ee_bit_shifter.sv
module ee_bit_shifter
    import spi_ee_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [4:0]  nbits,
    input  logic [15:0] tx,
    input  logic        miso,
    output logic        sck,
    output logic        mosi,
    output logic [15:0] rx,
    output logic        busy,
    output logic        done
);
    localparam int HW = $clog2(SCK_HALF) + 1;

    bit_state_t     bs;
    logic [HW-1:0]  tcnt;
    logic [4:0]     left;
    logic [15:0]    shreg;
    logic           phase_end;

    assign phase_end = (tcnt == HW'(SCK_HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bs    <= BS_IDLE;
            tcnt  <= '0;
            left  <= '0;
            shreg <= '0;
            rx    <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (bs)
                BS_IDLE: begin
                    if (start) begin
                        shreg <= tx << (5'd16 - nbits);
                        left  <= nbits;
                        tcnt  <= '0;
                        rx    <= '0;
                        bs    <= BS_LOW;
                    end
                end
                BS_LOW: begin
                    if (phase_end) begin
                        tcnt <= '0;
                        bs   <= BS_HIGH;
                    end else begin
                        tcnt <= tcnt + HW'(1);
                    end
                end
                BS_HIGH: begin
                    if (phase_end) begin
                        rx    <= {rx[14:0], miso};
                        shreg <= shreg << 1;
                        left  <= left - 5'd1;
                        tcnt  <= '0;
                        if (left == 5'd1) begin
                            bs   <= BS_IDLE;
                            done <= 1'b1;
                        end else begin
                            bs <= BS_LOW;
                        end
                    end else begin
                        tcnt <= tcnt + HW'(1);
                    end
                end
                default: bs <= BS_IDLE;
            endcase
        end
    end

    assign sck  = (bs == BS_HIGH);
    assign mosi = (bs != BS_IDLE) && shreg[15];
    assign busy = (bs != BS_IDLE);

    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));                       // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                               // R4
endmodule

// File: rtl/spi_eeprom_word_engine.sv
module spi_eeprom_word_engine
    import spi_ee_pkg::*;
#(
    parameter int CAP_WORDS  = 256,
    parameter int REQ_W      = 16,
    parameter int OPC_BITS   = 8,
    parameter int ADDR_BITS  = 8,
    parameter int PAGE_BYTES = 16,
    parameter int SCK_HALF   = 2,
    parameter int CS_GAP     = 2,
    parameter int POLL_LIMIT = 8,
    parameter int WR_CYCLES  = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [REQ_W-1:0] req_offset,
    input  logic [REQ_W-1:0] req_count,
    input  logic [15:0]      wr_data,
    output logic             wr_take,
    output logic             rd_valid,
    output logic [15:0]      rd_data,
    output logic             done,
    output logic             err,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int WW         = $clog2(CAP_WORDS) + 1;
    localparam int BAW        = WW + 1;
    localparam int PAGE_WORDS = PAGE_BYTES / 2;
    localparam int PLW        = $clog2(POLL_LIMIT + 1);
    localparam int TW         = $clog2(WR_CYCLES + CS_GAP + 1);

    ee_state_t        state, resume;
    logic [WW-1:0]    cur_word, next_word;
    logic [BAW-1:0]   byte_addr;
    logic [REQ_W-1:0] remain;
    logic [PLW-1:0]   polls;
    logic             is_write, launched, err_q, a8_hit;
    logic             range_bad, shifting, page_end;
    logic             sh_start, sh_busy, sh_done;
    logic [4:0]       sh_nbits;
    logic [15:0]      sh_tx, sh_rx;
    logic [TW-1:0]    tcnt;
    logic             tclr, gap_done, wait_done;

    ee_range_check #(.CAP_WORDS(CAP_WORDS), .REQ_W(REQ_W)) u_range (
        .offset(req_offset), .count(req_count), .bad(range_bad));

    ee_bit_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .nbits(sh_nbits),
        .tx(sh_tx), .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
        .rx(sh_rx), .busy(sh_busy), .done(sh_done));

    ee_cycle_counter #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tclr), .cnt(tcnt));

    assign byte_addr = {cur_word, 1'b0};
    assign next_word = cur_word + WW'(1);
    assign page_end  = ((next_word % WW'(PAGE_WORDS)) == '0);
    assign gap_done  = (tcnt >= TW'(CS_GAP - 1));
    assign wait_done = (tcnt >= TW'(WR_CYCLES - 1));
    assign tclr      = !(state == ST_CS_PULSE || state == ST_WRITE_WAIT);

    generate
        if (ADDR_BITS == 8 && BAW > 8) begin : g_hi_bit
            assign a8_hit = byte_addr[8];
        end else begin : g_no_hi_bit
            assign a8_hit = 1'b0;
        end
    endgenerate

    // Output and shifter-control process
    always_comb begin
        shifting  = (state == ST_POLL_CMD) || (state == ST_POLL_STAT) ||
                    (state == ST_WREN)     || (state == ST_CMD)       ||
                    (state == ST_ADDR)     || (state == ST_READ_WORD) ||
                    (state == ST_WRITE_WORD);
        spi_cs_n  = !shifting;
        req_ready = (state == ST_IDLE);
        sh_start  = shifting && !launched && !sh_busy;
        sh_nbits  = 5'(OPC_BITS);
        sh_tx     = '0;
        unique case (state)
            ST_POLL_CMD:   sh_tx = 16'(OPC_STATUS);
            ST_POLL_STAT:  sh_nbits = 5'd8;
            ST_WREN:       sh_tx = 16'(OPC_WREN);
            ST_CMD:        sh_tx = 16'((is_write ? OPC_WRITE : OPC_READ) |
                                       (a8_hit ? OPC_HI_BIT : 8'h00));
            ST_ADDR: begin
                sh_nbits = 5'(ADDR_BITS);
                sh_tx    = 16'(byte_addr);
            end
            ST_READ_WORD:  sh_nbits = 5'd16;
            ST_WRITE_WORD: begin
                sh_nbits = 5'd16;
                sh_tx    = {wr_data[7:0], wr_data[15:8]};
            end
            default: ;
        endcase
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            resume   <= ST_IDLE;
            cur_word <= '0;
            remain   <= '0;
            polls    <= '0;
            is_write <= 1'b0;
            launched <= 1'b0;
            err_q    <= 1'b0;
            wr_take  <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            wr_take  <= 1'b0;
            rd_valid <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            if (sh_start) begin
                launched <= 1'b1;
                if (state == ST_WRITE_WORD) wr_take <= 1'b1;
            end
            if (sh_done) launched <= 1'b0;

            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (range_bad) begin
                            err_q <= 1'b1;
                            state <= ST_FINISH;
                        end else begin
                            err_q    <= 1'b0;
                            cur_word <= WW'(req_offset);
                            remain   <= req_count;
                            is_write <= req_write;
                            polls    <= '0;
                            state    <= ST_POLL_CMD;
                        end
                    end
                end
                ST_POLL_CMD:  if (sh_done) state <= ST_POLL_STAT;
                ST_POLL_STAT: begin
                    if (sh_done) begin
                        if (!sh_rx[0]) begin
                            polls  <= '0;
                            resume <= is_write ? ST_WREN : ST_CMD;
                            state  <= ST_CS_PULSE;
                        end else if (polls == PLW'(POLL_LIMIT - 1)) begin
                            err_q <= 1'b1;
                            state <= ST_FINISH;
                        end else begin
                            polls  <= polls + PLW'(1);
                            resume <= ST_POLL_CMD;
                            state  <= ST_CS_PULSE;
                        end
                    end
                end
                ST_CS_PULSE: if (gap_done) state <= resume;
                ST_WREN: begin
                    if (sh_done) begin
                        resume <= ST_CMD;
                        state  <= ST_CS_PULSE;
                    end
                end
                ST_CMD:  if (sh_done) state <= ST_ADDR;
                ST_ADDR: if (sh_done) state <= is_write ? ST_WRITE_WORD : ST_READ_WORD;
                ST_READ_WORD: begin
                    if (sh_done) begin
                        rd_valid <= 1'b1;
                        rd_data  <= {sh_rx[7:0], sh_rx[15:8]};
                        cur_word <= next_word;
                        remain   <= remain - REQ_W'(1);
                        if (remain == REQ_W'(1)) state <= ST_FINISH;
                    end
                end
                ST_WRITE_WORD: begin
                    if (sh_done) begin
                        cur_word <= next_word;
                        remain   <= remain - REQ_W'(1);
                        if (remain == REQ_W'(1) || page_end) state <= ST_WRITE_WAIT;
                    end
                end
                ST_WRITE_WAIT: begin
                    if (wait_done) state <= (remain == '0) ? ST_FINISH : ST_POLL_CMD;
                end
                ST_FINISH: begin
                    done  <= 1'b1;
                    err   <= err_q;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n);                                        // R4
    AST_READ_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ_WORD) |-> !spi_mosi);                        // R5
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);                                                 // R1
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        polls < PLW'(POLL_LIMIT));                                     // R3
    AST_READY_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (spi_cs_n && !spi_sck));                         // R13
    AST_RDVALID_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !is_write);                                       // R11
    AST_TAKE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> (state == ST_WRITE_WORD));                         // R9
endmodule

// File: tb/tb_spi_eeprom_word_engine.sv
`timescale 1ns/1ps
module tb_spi_eeprom_word_engine;
    localparam int CAP   = 256;
    localparam int PAGEB = 16;
    localparam int PW    = PAGEB / 2;
    localparam int WRC   = 40;
    localparam int PLIM  = 8;
    localparam int BUSY  = 200;

    localparam int MS_IDLE = 0, MS_OP = 1, MS_AD = 2, MS_RD = 3, MS_WR = 4, MS_ST = 5, MS_IGN = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_offset = '0, req_count = '0;
    logic [15:0] wr_data;
    logic req_ready, wr_take, rd_valid, done, err;
    logic [15:0] rd_data;
    logic spi_cs_n, spi_sck, spi_mosi;
    logic spi_miso = 1'b0;

    always #5 clk = ~clk;

    spi_eeprom_word_engine #(
        .CAP_WORDS(CAP), .REQ_W(16), .OPC_BITS(8), .ADDR_BITS(8),
        .PAGE_BYTES(PAGEB), .SCK_HALF(2), .CS_GAP(2),
        .POLL_LIMIT(PLIM), .WR_CYCLES(WRC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_offset(req_offset), .req_count(req_count),
        .wr_data(wr_data), .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .err(err), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    int checks = 0, errors = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int seed, input int i);
        return 16'(i * 40503 + seed * 7919 + (i >> 3));
    endfunction

    // Behavioural EEPROM
    logic [7:0]  mem [512];
    logic [15:0] exp_img [CAP];
    logic [8:0]  m_addr;
    logic [7:0]  m_sr;
    logic        m_hi, m_wel, m_rdcmd, stuck = 1'b0, prev_cs = 1'b1, prev_sck = 1'b0, gap_on = 1'b0;
    int m_stage = MS_IDLE, m_bits = 0, m_busy = 0, wr_bytes = 0, gap_len = 0, min_gap = 1000000;
    int n_sel = 0, n_rdsr = 0, n_wren = 0, n_wr = 0, n_rd = 0, mosi_bad = 0, no_wel = 0, n_done = 0;
    logic [7:0] m_status;

    always @(negedge clk) begin
        if (rst_n) begin
            if (m_busy > 0) m_busy--;
            if (gap_on) gap_len++;
            if (prev_cs && !spi_cs_n) begin
                n_sel++; m_stage = MS_OP; m_bits = 0;
                if (gap_on) begin
                    if (gap_len < min_gap) min_gap = gap_len;
                    gap_on = 1'b0;
                end
            end
            if (!prev_cs && spi_cs_n) begin
                if (m_stage == MS_WR && wr_bytes > 0) begin
                    m_busy = BUSY; m_wel = 1'b0; gap_on = 1'b1; gap_len = 0;
                end
                m_stage = MS_IDLE;
            end
            if (!spi_cs_n && spi_sck && !prev_sck) begin
                if (m_stage == MS_RD && spi_mosi) mosi_bad++;
                m_sr = {m_sr[6:0], spi_mosi};
                m_bits++;
                if (m_bits == 8) begin
                    m_bits = 0;
                    case (m_stage)
                        MS_OP: begin
                            m_hi = m_sr[3];
                            if (m_sr == 8'h05) begin n_rdsr++; m_stage = MS_ST; end
                            else if (m_sr == 8'h06) begin n_wren++; m_wel = 1'b1; m_stage = MS_IGN; end
                            else if ((m_sr & 8'hF7) == 8'h03) begin n_rd++; m_rdcmd = 1'b1; m_stage = MS_AD; end
                            else if ((m_sr & 8'hF7) == 8'h02) begin
                                n_wr++; if (!m_wel) no_wel++;
                                m_rdcmd = 1'b0; wr_bytes = 0; m_stage = MS_AD;
                            end else m_stage = MS_IGN;
                        end
                        MS_AD: begin
                            m_addr = {m_hi, m_sr};
                            m_stage = m_rdcmd ? MS_RD : MS_WR;
                        end
                        MS_WR: begin
                            if (m_wel) mem[m_addr] = m_sr;
                            wr_bytes++;
                            m_addr = {m_addr[8:4], m_addr[3:0] + 4'd1};
                        end
                        MS_RD: m_addr = m_addr + 9'd1;
                        default: ;
                    endcase
                end
            end
            if (!spi_cs_n && !spi_sck && prev_sck) begin
                m_status = {7'b0, (m_busy > 0) || stuck};
                if (m_stage == MS_ST) spi_miso = m_status[7 - m_bits];
                else if (m_stage == MS_RD) spi_miso = mem[m_addr][7 - m_bits];
                else spi_miso = 1'b0;
            end
            prev_cs = spi_cs_n;
            prev_sck = spi_sck;
        end
    end

    // Host side
    int seed_cur = 0, base_cur = 0, wr_idx = 0, rd_n = 0;
    logic [15:0] rd_buf [CAP];
    assign wr_data = pat(seed_cur, base_cur + wr_idx);

    always @(negedge clk) begin
        if (wr_take) wr_idx++;
        if (rd_valid && rd_n < CAP) begin rd_buf[rd_n] = rd_data; rd_n++; end
        if (done) n_done++;
    end

    task automatic run_req(input logic w, input int off, input int cnt, input int seed, output logic e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        seed_cur = seed; base_cur = off; wr_idx = 0; rd_n = 0;
        req_valid = 1'b1; req_write = w; req_offset = 16'(off); req_count = 16'(cnt);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        e = err;
    endtask

    task automatic do_write(input int off, input int cnt, input int seed);
        logic e;
        int w0, wr0, pages;
        w0 = n_wren; wr0 = n_wr;
        pages = (off + cnt - 1) / PW - off / PW + 1;
        run_req(1'b1, off, cnt, seed, e);
        for (int i = off; i < off + cnt; i++) exp_img[i] = pat(seed, i);
        chk("R10", $sformatf("write %0d+%0d err", off, cnt), 32'(e), 0);
        chk("R10", $sformatf("write %0d+%0d enables", off, cnt), 32'(n_wren - w0), 32'(pages));
        chk("R9", $sformatf("write %0d+%0d takes", off, cnt), 32'(wr_idx), 32'(cnt));
        chk("R9", $sformatf("write %0d+%0d commands", off, cnt), 32'(n_wr - wr0), 32'(pages));
    endtask

    task automatic cmp_array(input string req, input string what);
        int bad = -1;
        for (int i = CAP - 1; i >= 0; i--)
            if ({mem[2*i+1], mem[2*i]} !== exp_img[i]) bad = i;
        chk(req, {what, " first bad word"}, bad, 32'hFFFF_FFFF);
    endtask

    task automatic do_read(input string req, input int off, input int cnt);
        logic e;
        int r0, bad = -1;
        r0 = n_rd;
        run_req(1'b0, off, cnt, 0, e);
        chk(req, $sformatf("read %0d+%0d err", off, cnt), 32'(e), 0);
        chk("R11", $sformatf("read %0d+%0d words", off, cnt), 32'(rd_n), 32'(cnt));
        chk("R11", $sformatf("read %0d+%0d commands", off, cnt), 32'(n_rd - r0), 1);
        for (int i = cnt - 1; i >= 0; i--)
            if (rd_buf[i] !== exp_img[off + i]) bad = i;
        chk(req, $sformatf("read %0d+%0d first bad", off, cnt), bad, 32'hFFFF_FFFF);
    endtask

    task automatic do_reject(input int off, input int cnt);
        logic e;
        int s0;
        s0 = n_sel;
        run_req(1'b0, off, cnt, 0, e);
        chk("R1", $sformatf("reject %0d+%0d err", off, cnt), 32'(e), 1);
        chk("R1", $sformatf("reject %0d+%0d selects", off, cnt), 32'(n_sel - s0), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic e;
        int q0, s0, r0, req_total;
        int offs [6] = '{0, 5, 7, 126, 127, 247};
        int cnts [4] = '{1, 2, 3, 9};
        for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
        for (int i = 0; i < CAP; i++) exp_img[i] = 16'hFFFF;
        m_wel = 1'b0;
        repeat (4) @(negedge clk);
        // R13 reset state
        chk("R13", "reset ready", 32'(req_ready), 1);
        chk("R4", "reset cs_n", 32'(spi_cs_n), 1);
        chk("R4", "reset sck", 32'(spi_sck), 0);
        chk("R11", "reset rd_valid", 32'(rd_valid), 0);
        rst_n = 1'b1;
        req_total = 0;

        // Whole array write then read: R6 R7 R8 R10
        do_write(0, CAP, 1); req_total++;
        cmp_array("R7", "full write image");
        chk("R8", "byte order word 3 low", 32'(mem[6]), 32'(exp_img[3][7:0]));
        chk("R8", "byte order word 3 high", 32'(mem[7]), 32'(exp_img[3][15:8]));
        do_read("R6", 0, CAP); req_total++;

        // Sweep around page ends and the top of the array: R6 R10
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 4; b++) begin
                do_write(offs[a], cnts[b], 10 * a + b + 2); req_total++;
            end
        cmp_array("R10", "sweep image");

        // Stream across byte address 256: R7 R11
        do_read("R7", 126, 4); req_total++;
        do_read("R6", 255, 1); req_total++;
        do_read("R6", 37, 11); req_total++;

        // Rejected requests: R1
        do_reject(256, 1); req_total++;
        do_reject(0, 0); req_total++;
        do_reject(250, 7); req_total++;

        // Part stuck busy: R3 R2
        stuck = 1'b1;
        q0 = n_rdsr; r0 = n_rd; s0 = n_sel;
        run_req(1'b0, 0, 1, 0, e); req_total++;
        chk("R3", "timeout err", 32'(e), 1);
        chk("R3", "timeout polls", 32'(n_rdsr - q0), PLIM);
        chk("R2", "timeout selects", 32'(n_sel - s0), PLIM);
        chk("R3", "timeout no read", 32'(n_rd - r0), 0);
        stuck = 1'b0;
        do_read("R2", 0, CAP); req_total++;

        chk("R5", "mosi high during read data", 32'(mosi_bad), 0);
        chk("R9", "write without enable", 32'(no_wel), 0);
        chk("R12", "write-cycle gap", 32'(min_gap >= WRC), 1);
        @(negedge clk);
        chk("R13", "done pulses", 32'(n_done), 32'(req_total));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule